// File: doc/BRIEF.md
# DC-Removal High-Pass Filter

This block strips the DC component from a stream of 24-bit two's complement audio samples. It sits between a decimation stage, which hands it one sample per output period with a valid strobe, and a serial output port that consumes the filtered sample. Its corner frequency scales with the sample rate. The fixed feedback shift of 13 puts the -3 dB point near fS/48000, which is roughly 1 Hz at 48 kHz, so audible content passes essentially untouched.

The filter is a single-pole recursive structure. Each accepted sample updates an accumulator that holds the output scaled by 2^FRAC_W. The accumulator adds the first difference of the input and subtracts its own value shifted right by SHIFT_K. The integer part of the new accumulator is clamped to the 24-bit range and registered. A bypass input, active high, sends the raw sample to the output instead. The recursion keeps running while bypass is asserted, so enabling the filter again picks up a settled state rather than producing a large step.

Top module: `dc_removal_hpf`

## Requirements
- R1: While rstN is low, resultValid and resultOut are 0, and the stored previous input and the accumulator are cleared. The first filtered sample after reset therefore equals its input exactly.
- R2: resultValid is high in exactly the cycles that follow a rising clock edge at which sampleValid was high. This gives one cycle of latency.
- R3: resultOut changes only on a clock edge at which sampleValid is high. Otherwise it holds its value.
- R4: Samples are 24-bit two's complement. On each valid sample x, with previous input p and accumulator a, the new accumulator is a' = a + ((x - p) * 2^13) - (a >>> 13), using an arithmetic shift. The filtered output is floor(a' / 2^13) after clamping, and p becomes x.
- R5: After a DC step of 1,000,000 from a zero state, the output has fallen below 1% of the step within 60,000 samples.
- R6: The filtered output saturates rather than wrapping. Values above 8,388,607 give 8,388,607, and values below -8,388,608 give -8,388,608.
- R7: When bypassEn is 1 on a valid sample, resultOut becomes that sample unchanged.
- R8: The recursion of R4 advances on every valid sample, whether or not bypass is asserted. After bypass is released, the output matches a filter that never stopped running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Strobe marking a new input sample |
| sampleIn | input | 24 | Input sample, two's complement |
| bypassEn | input | 1 | 1 passes the sample through, 0 filters it |
| resultValid | output | 1 | Strobe marking a new output sample |
| resultOut | output | 24 | Output sample, two's complement |

## Verification
The assertions assume that sampleValid and bypassEn are low or stable throughout reset. They also assume that the accumulator never leaves its headroom. That holds whenever the input is a legal 24-bit signal, because the output of a stable first-order high-pass stays within about twice full scale. The stimulus keeps sampleValid low during every reset. It drives only legal 24-bit values, and the largest are the full-scale swings of the saturation test. Every output is compared against an integer model of the recursion, and the decay, saturation and bypass cases add checks stated directly in terms of the requirements.

// File: rtl/hpf_pkg.sv
package hpf_pkg;
  // Strobes the control sends to the datapath.
  typedef struct packed {
    logic update;    // accept a sample this edge
    logic passThru;  // route the raw sample to the output
  } hpfStrobe_t;
endpackage

// File: rtl/hpf_ctrl.sv
module hpf_ctrl
  import hpf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleValid,
  input  logic       bypassEn,
  output hpfStrobe_t strobe,
  output logic       resultValid
);
  always_comb begin
    strobe.update   = sampleValid;
    strobe.passThru = bypassEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resultValid <= 1'b0;
    else       resultValid <= sampleValid;
  end

  // R2: output strobe follows the input strobe one cycle later
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> resultValid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> !resultValid);

  // R1: reset forces the strobe low
  always_ff @(posedge clk) begin
    if (!rstN) assert_reset_valid_R1: assert (resultValid == 1'b0);
  end
endmodule

// File: rtl/hpf_datapath.sv
module hpf_datapath
  import hpf_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int SHIFT_K = 13,
  parameter int FRAC_W  = 13,
  parameter int HEAD_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  hpfStrobe_t        strobe,
  input  logic [DATA_W-1:0] sampleIn,
  output logic [DATA_W-1:0] resultOut
);
  localparam int ACC_W = DATA_W + HEAD_W + FRAC_W;
  localparam int EXT_W = ACC_W - DATA_W - 1;
  localparam logic signed [ACC_W-1:0] SAT_HI = (ACC_W'(1) <<< (DATA_W-1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] SAT_LO = ~SAT_HI;

  logic signed [DATA_W-1:0] xPrev;
  logic signed [ACC_W-1:0]  acc;
  logic signed [DATA_W:0]   diffNarrow;
  logic signed [ACC_W-1:0]  diffScaled;
  logic signed [ACC_W-1:0]  leak;
  logic signed [ACC_W-1:0]  accNext;
  logic signed [ACC_W-1:0]  yWide;
  logic        [DATA_W-1:0] yClamped;

  always_comb begin
    diffNarrow = {sampleIn[DATA_W-1], sampleIn} - {xPrev[DATA_W-1], xPrev};
    diffScaled = {{EXT_W{diffNarrow[DATA_W]}}, diffNarrow} <<< FRAC_W;
    leak       = acc >>> SHIFT_K;
    accNext    = acc + diffScaled - leak;
    yWide      = accNext >>> FRAC_W;
  end

  // Clamp to the sample range (R6)
  always_comb begin
    if (yWide > SAT_HI)      yClamped = SAT_HI[DATA_W-1:0];
    else if (yWide < SAT_LO) yClamped = SAT_LO[DATA_W-1:0];
    else                     yClamped = yWide[DATA_W-1:0];
  end

  // The recursion runs regardless of bypass (R8)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xPrev     <= '0;
      acc       <= '0;
      resultOut <= '0;
    end else if (strobe.update) begin
      xPrev     <= sampleIn;
      acc       <= accNext;
      resultOut <= strobe.passThru ? sampleIn : yClamped;
    end
  end

  // R3: output only moves on an accepted sample
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.update |=> $stable(resultOut));

  // R7: bypassed sample appears unchanged
  assert_bypass_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.update && strobe.passThru) |=> resultOut == $past(sampleIn));

  // R4: a quiet state with a repeated input yields a zero output
  assert_quiet_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.update && !strobe.passThru && sampleIn == xPrev && acc == '0)
      |=> resultOut == '0);
endmodule

// File: rtl/dc_removal_hpf.sv
module dc_removal_hpf
  import hpf_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int SHIFT_K = 13,
  parameter int FRAC_W  = 13,
  parameter int HEAD_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              bypassEn,
  output logic              resultValid,
  output logic [DATA_W-1:0] resultOut
);
  hpfStrobe_t strobe;

  hpf_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .bypassEn    (bypassEn),
    .strobe      (strobe),
    .resultValid (resultValid)
  );

  hpf_datapath #(
    .DATA_W  (DATA_W),
    .SHIFT_K (SHIFT_K),
    .FRAC_W  (FRAC_W),
    .HEAD_W  (HEAD_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .sampleIn  (sampleIn),
    .resultOut (resultOut)
  );
endmodule

// File: tb/tb_dc_removal_hpf.sv
`timescale 1ns/1ps
module tb_dc_removal_hpf;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [23:0] sampleIn = '0;
  logic        bypassEn = 1'b0;
  logic        resultValid;
  logic [23:0] resultOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  longint mAcc = 0;
  longint mPrev = 0;

  always #2.5 clk = ~clk;

  dc_removal_hpf dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .bypassEn(bypassEn), .resultValid(resultValid), .resultOut(resultOut)
  );

  task automatic check(input string req, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint outSigned();
    return longint'(signed'(resultOut));
  endfunction

  // Integer model of the recursion; returns the expected output.
  function automatic longint modelStep(input longint x, input bit byp);
    longint y;
    mAcc  = mAcc + ((x - mPrev) <<< 13) - (mAcc >>> 13);
    mPrev = x;
    y = mAcc >>> 13;
    if (y > 8388607) y = 8388607;
    if (y < -8388608) y = -8388608;
    return byp ? x : y;
  endfunction

  task automatic sendSample(input longint x, input bit byp, input string req);
    longint exp;
    @(negedge clk);
    sampleIn = x[23:0]; bypassEn = byp; sampleValid = 1'b1;
    @(posedge clk); #1;
    exp = modelStep(x, byp);
    check(req, outSigned(), exp);
    check("R2 valid", longint'(resultValid), 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sampleValid = 1'b0;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    sampleValid = 1'b0; rstN = 1'b0;
    @(posedge clk); #1;
    check("R1 reset out", outSigned(), 0);
    check("R1 reset valid", longint'(resultValid), 0);
    mAcc = 0; mPrev = 0;
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic testResetAndFirst();
    doReset();
    sendSample(12345, 0, "R1 first sample after reset");
    sendSample(-777, 0, "R4 second sample");
  endtask

  task automatic testGaps();
    longint held;
    doReset();
    sendSample(400000, 0, "R4 gap lead-in");
    held = outSigned();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); sampleValid = 1'b0; sampleIn = 24'h5A5A5A; bypassEn = 1'b1;
      @(posedge clk); #1;
      check("R3 hold during gap", outSigned(), held);
      check("R2 valid low in gap", longint'(resultValid), 0);
    end
    sendSample(400000, 0, "R4 after gap");
  endtask

  task automatic testDcStep();
    longint last = 0;
    doReset();
    for (int i = 0; i < 60000; i++) begin
      sendSample(1000000, 0, "R4 DC step");
      last = outSigned();
    end
    check("R5 decay below 1%", (last < 10000 && last >= 0) ? 1 : 0, 1);
    idle(1);
  endtask

  task automatic testTone();
    longint x;
    doReset();
    for (int i = 0; i < 3000; i++) begin
      int ph = i % 400;
      x = 3000000 + ((ph < 200) ? (ph * 10000) : ((400 - ph) * 10000)) - 1000000;
      sendSample(x, 0, "R4 low-frequency tone");
    end
    idle(1);
  endtask

  task automatic testSaturation();
    doReset();
    sendSample(-8388608, 0, "R4 negative full scale");
    sendSample(8388607, 0, "R6 positive clamp");
    check("R6 clamp high value", outSigned(), 8388607);
    sendSample(-8388608, 0, "R6 negative clamp");
    check("R6 clamp low value", outSigned(), -8388608);
    idle(1);
  endtask

  task automatic testBypass();
    longint y;
    doReset();
    for (int i = 0; i < 20000; i++) sendSample(500000, 1, "R7 bypass pass-through");
    check("R7 bypass value", outSigned(), 500000);
    sendSample(500000, 0, "R8 re-enable continuity");
    y = outSigned();
    check("R8 no large step", (y < 125000) ? 1 : 0, 1);
    sendSample(-200000, 1, "R7 bypass negative");
    sendSample(-200000, 0, "R8 re-enable after negative");
    idle(1);
  endtask

  initial begin
    #20;
    testResetAndFirst();
    testGaps();
    testSaturation();
    testTone();
    testBypass();
    testDcStep();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #900000;
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule